// File: doc/BRIEF.md
# Start-Gap Line Address Rotator

This block spreads write wear over a region of memory lines. The region holds one physical line more than its logical capacity, and that spare slot is the gap. A logical line number is turned into a physical line number from only two registers: a rotation offset (start) and the gap position. No mapping table is needed. Each access is translated combinationally in the cycle it is presented.

A counter counts accepted writes. Each time the count reaches a programmable interval, the block asks the memory array to copy the line just below the gap into the gap. After the array acknowledges the copy, the gap moves down by one. When the gap reaches physical line 0, the next move copies the top physical line into line 0. The gap then returns to the top and the rotation offset advances by one. Over time every logical line visits every physical slot.

While a move is outstanding, accesses whose physical address is the source or the destination of that move are held off through the ready signal. All other accesses continue normally.

Top module: `startgap_rotator`

## Requirements
- R1: After reset, the rotation offset is 0, the gap sits at physical line N (N = LINES), no move is pending, and every logical line L maps to physical line L.
- R2: The physical address is t = (L + start) mod N when t < gap, and t + 1 when t >= gap.
- R3: The physical address always lies in 0..N and never equals the current gap position.
- R4: An accepted write is a cycle with req_valid, req_write and req_ready all high. On the clock edge that accepts the interval-th write since the last move was issued, mv_valid rises. If the gap is above 0, the move has mv_src = gap-1 and mv_dst = gap.
- R5: mv_valid, mv_src and mv_dst stay unchanged until the edge on which mv_ack is high. On that edge mv_valid falls and a gap above 0 decreases by one. The logical line that lived at mv_src then maps to the old mv_dst.
- R6: When the gap is 0, the move has mv_src = N and mv_dst = 0. On its acknowledgement the gap returns to N and start advances by one modulo N.
- R7: While a move is pending, req_ready is low for an access whose physical address equals mv_src or mv_dst. It is high for every other access.
- R8: Writes accepted while a move is pending keep counting, saturating at 2^CNTW-1. A write accepted in the same cycle as mv_ack is translated with the pre-move mapping. No new move is issued on the acknowledging edge. If the count has already reached the interval, the next move is issued on the following edge.
- R9: Reads (req_write low) do not advance the write count. An interval of 0 disables moves entirely.
- R10: When the testbench memory model performs each commanded copy, reading any logical line returns the data last written to it, through any number of moves and rotation wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval | input | CNTW | Number of accepted writes between moves; 0 disables moves |
| req_valid | input | 1 | Access present |
| req_write | input | 1 | Access is a write |
| req_la | input | LAW | Logical line number, 0..N-1 |
| req_ready | output | 1 | Access may proceed this cycle |
| req_pa | output | AW | Physical line number |
| mv_valid | output | 1 | Move command pending |
| mv_src | output | AW | Physical line to copy from |
| mv_dst | output | AW | Physical line to copy to |
| mv_ack | input | 1 | Memory array has completed the move |

## Verification
Two events can coincide in one cycle: a write being accepted and counted, and the acknowledgement of a pending move, which changes the mapping registers. The bench issues a move and then fills the write count past the interval with writes to uninvolved lines. It presents one more write together with mv_ack. That write's address is judged against the pre-move mapping. The bench then checks that mv_valid is low just after the edge and high one edge later, with the source and destination taken from the new gap. A second coincidence is the interval-th write and the move it triggers. This is judged by mv_valid rising on the very edge that accepts the write.

// File: rtl/startgap_rotator.sv
`timescale 1ns/1ps
module startgap_rotator #(
  parameter int LINES = 8,
  parameter int CNTW  = 4,
  localparam int LAW  = $clog2(LINES),
  localparam int AW   = $clog2(LINES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] interval,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [LAW-1:0]  req_la,
  output logic            req_ready,
  output logic [AW-1:0]   req_pa,
  output logic            mv_valid,
  output logic [AW-1:0]   mv_src,
  output logic [AW-1:0]   mv_dst,
  input  logic            mv_ack
);

  logic [LAW-1:0]  start_q;
  logic [AW-1:0]   gap_q;
  logic [CNTW-1:0] wcnt_q;

  wire [LAW:0] sum  = {1'b0, req_la} + {1'b0, start_q};
  wire [LAW:0] rot  = (sum >= (LAW+1)'(LINES)) ? sum - (LAW+1)'(LINES) : sum;
  wire [AW-1:0] base = AW'(rot);

  assign req_pa    = base + ((base >= gap_q) ? AW'(1) : AW'(0));
  assign req_ready = !(mv_valid && (req_pa == mv_src || req_pa == mv_dst));

  wire           acc     = req_valid && req_write && req_ready;
  wire [CNTW:0]  cnt_nx  = {1'b0, wcnt_q} + {{CNTW{1'b0}}, acc};
  wire [CNTW-1:0] cnt_sat = cnt_nx[CNTW] ? '1 : cnt_nx[CNTW-1:0];
  wire           issue   = !mv_valid && (interval != '0) && (cnt_nx >= {1'b0, interval});
  wire           gap_zero = (gap_q == '0);
  wire [LAW-1:0] start_inc = (start_q == LAW'(LINES - 1)) ? '0 : start_q + LAW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      gap_q    <= AW'(LINES);
      wcnt_q   <= '0;
      mv_valid <= 1'b0;
      mv_src   <= '0;
      mv_dst   <= '0;
    end else begin
      wcnt_q <= issue ? '0 : cnt_sat;
      if (issue) begin
        mv_valid <= 1'b1;
        if (gap_zero) begin
          mv_src <= AW'(LINES);
          mv_dst <= '0;
        end else begin
          mv_src <= gap_q - AW'(1);
          mv_dst <= gap_q;
        end
      end else if (mv_valid && mv_ack) begin
        mv_valid <= 1'b0;
        if (gap_zero) begin
          gap_q   <= AW'(LINES);
          start_q <= start_inc;
        end else begin
          gap_q <= gap_q - AW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/startgap_rotator_chk.sv
`timescale 1ns/1ps
module startgap_rotator_chk #(
  parameter int LINES = 8,
  localparam int LAW  = $clog2(LINES),
  localparam int AW   = $clog2(LINES + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [AW-1:0]  req_pa,
  input logic           mv_valid,
  input logic [AW-1:0]  mv_src,
  input logic [AW-1:0]  mv_dst,
  input logic           mv_ack,
  input logic [AW-1:0]  gap_q,
  input logic [LAW-1:0] start_q
);

  p_pa_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_pa <= AW'(LINES));

  p_pa_not_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_pa != gap_q);

  p_move_adjacent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> ((mv_dst == mv_src + AW'(1)) || (mv_src == AW'(LINES) && mv_dst == '0)));

  p_move_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ack) |=> (mv_valid && $stable(mv_src) && $stable(mv_dst)));

  p_gap_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ack && gap_q != '0) |=> (gap_q == $past(gap_q) - AW'(1) && $stable(start_q)));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ack && gap_q == '0) |=>
      (gap_q == AW'(LINES) &&
       start_q == (($past(start_q) == LAW'(LINES - 1)) ? '0 : $past(start_q) + LAW'(1))));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mv_valid && (req_pa == mv_src || req_pa == mv_dst)) |-> !req_ready);

  p_no_issue_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ack) |=> !mv_valid);

endmodule

bind startgap_rotator startgap_rotator_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/tb_startgap_rotator.sv
`timescale 1ns/1ps
module tb_startgap_rotator;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int CNTW = 4;
  localparam int LAW  = $clog2(N);
  localparam int AW   = $clog2(N + 1);
  localparam int CMAX = (1 << CNTW) - 1;
  localparam int RST_PA [N] = '{0, 1, 2, 3, 4, 5, 6, 7};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNTW-1:0] interval = '0;
  logic req_valid = 1'b0, req_write = 1'b0, mv_ack = 1'b0;
  logic [LAW-1:0] req_la = '0;
  logic req_ready, mv_valid;
  logic [AW-1:0] req_pa, mv_src, mv_dst;

  startgap_rotator #(.LINES(N), .CNTW(CNTW)) dut (
    .clk(clk), .rst_n(rst_n), .interval(interval),
    .req_valid(req_valid), .req_write(req_write), .req_la(req_la),
    .req_ready(req_ready), .req_pa(req_pa),
    .mv_valid(mv_valid), .mv_src(mv_src), .mv_dst(mv_dst), .mv_ack(mv_ack));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int s_m = 0, g_m = N, cnt_m = 0, psi = 0;
  bit pend_m = 0;
  int esrc = 0, edst = 0;
  int mem [N+1];
  int shadow [N];
  bit saw_wrap = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_pa(input int la);
    int t;
    t = (la + s_m) % N;
    return (t >= g_m) ? t + 1 : t;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic set_expected_move();
    if (g_m == 0) begin esrc = N; edst = 0; end
    else begin esrc = g_m - 1; edst = g_m; end
  endtask

  task automatic write_line(input int la, input int data);
    int pa;
    req_valid = 1; req_write = 1; req_la = LAW'(la);
    #1;
    pa = ref_pa(la);
    chk(req_ready == 1'b1, "R7 free write ready", int'(req_ready), 1);
    chk(int'(req_pa) == pa, "R2 write address", int'(req_pa), pa);
    mem[pa] = data; shadow[la] = data;
    @(posedge clk);
    if (!pend_m && psi != 0 && cnt_m + 1 >= psi) begin
      pend_m = 1; cnt_m = 0; set_expected_move();
    end else begin
      cnt_m = (cnt_m + 1 > CMAX) ? CMAX : cnt_m + 1;
    end
    @(negedge clk);
    req_valid = 0; req_write = 0;
    #1;
    chk(mv_valid == pend_m, "R4 move raise", int'(mv_valid), int'(pend_m));
  endtask

  task automatic read_line(input int la);
    int pa;
    req_valid = 1; req_write = 0; req_la = LAW'(la);
    #1;
    pa = ref_pa(la);
    chk(int'(req_pa) == pa, "R2 read address", int'(req_pa), pa);
    chk(mem[pa] == shadow[la], "R10 read data", mem[pa], shadow[la]);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(mv_valid == pend_m, "R9 reads do not count", int'(mv_valid), int'(pend_m));
  endtask

  task automatic probe_stall();
    int stl, fre;
    stl = -1; fre = -1;
    for (int la = 0; la < N; la++) begin
      if (ref_pa(la) == esrc) stl = la;
      else if (fre < 0 && ref_pa(la) != edst) fre = la;
    end
    req_valid = 1; req_write = 0; req_la = LAW'(stl);
    #1;
    chk(req_ready == 1'b0, "R7 stall source", int'(req_ready), 0);
    req_la = LAW'(fre);
    #1;
    chk(req_ready == 1'b1, "R7 other line ready", int'(req_ready), 1);
    req_valid = 0;
  endtask

  task automatic ack_edge();
    if (g_m == 0) begin g_m = N; s_m = (s_m + 1) % N; saw_wrap = 1; end
    else g_m = g_m - 1;
    pend_m = 0;
  endtask

  task automatic service_move();
    int moved;
    chk(int'(mv_src) == esrc, (g_m == 0) ? "R6 wrap src" : "R4 move src", int'(mv_src), esrc);
    chk(int'(mv_dst) == edst, (g_m == 0) ? "R6 wrap dst" : "R4 move dst", int'(mv_dst), edst);
    moved = -1;
    for (int la = 0; la < N; la++) if (ref_pa(la) == esrc) moved = la;
    probe_stall();
    mem[edst] = mem[esrc];
    @(posedge clk); @(negedge clk); #1;
    chk(mv_valid == 1'b1 && int'(mv_src) == esrc, "R5 move held", int'(mv_src), esrc);
    mv_ack = 1;
    @(posedge clk);
    ack_edge();
    @(negedge clk);
    mv_ack = 0;
    #1;
    chk(mv_valid == 1'b0, "R5 move cleared", int'(mv_valid), 0);
    req_valid = 1; req_la = LAW'(moved);
    #1;
    chk(int'(req_pa) == edst, "R5 R6 moved line remap", int'(req_pa), edst);
    req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int fre;
    for (int i = 0; i <= N; i++) mem[i] = 0;
    for (int i = 0; i < N; i++) shadow[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(mv_valid == 1'b0, "R1 no move after reset", int'(mv_valid), 0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      req_valid = 1; req_write = 0; req_la = LAW'(i);
      #1;
      chk(int'(req_pa) == RST_PA[i], "R1 identity map", int'(req_pa), RST_PA[i]);
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    end
    req_valid = 0;
    @(negedge clk);

    psi = 3; interval = CNTW'(psi);
    for (int i = 0; i < 30; i++) begin
      write_line(i % N, 100 + i);
      if (pend_m) service_move();
    end
    chk(saw_wrap, "R6 wrap reached", int'(saw_wrap), 1);
    for (int la = 0; la < N; la++) read_line(la);

    psi = 2; interval = CNTW'(psi); cnt_m = 0;
    @(negedge clk);
    write_line(1, 200);
    if (pend_m) service_move();
    write_line(2, 201);
    if (!pend_m) write_line(3, 202);
    chk(pend_m && mv_valid, "R4 move pending", int'(mv_valid), 1);
    chk(int'(mv_src) == esrc, "R4 move src", int'(mv_src), esrc);
    mem[edst] = mem[esrc];
    for (int k = 0; k < 2; k++) begin
      fre = -1;
      for (int la = 0; la < N; la++)
        if (fre < 0 && ref_pa(la) != esrc && ref_pa(la) != edst && la != k) fre = la;
      write_line(fre, 300 + k);
    end
    chk(cnt_m == 2, "R8 count while pending", cnt_m, 2);
    fre = -1;
    for (int la = N - 1; la >= 0; la--)
      if (fre < 0 && ref_pa(la) != esrc && ref_pa(la) != edst) fre = la;
    req_valid = 1; req_write = 1; req_la = LAW'(fre); mv_ack = 1;
    #1;
    chk(req_ready == 1'b1, "R8 write with ack ready", int'(req_ready), 1);
    chk(int'(req_pa) == ref_pa(fre), "R8 pre-move mapping", int'(req_pa), ref_pa(fre));
    mem[ref_pa(fre)] = 400; shadow[fre] = 400;
    @(posedge clk);
    ack_edge();
    cnt_m = (cnt_m + 1 > CMAX) ? CMAX : cnt_m + 1;
    @(negedge clk);
    mv_ack = 0; req_valid = 0; req_write = 0;
    #1;
    chk(mv_valid == 1'b0, "R8 no issue on ack edge", int'(mv_valid), 0);
    @(posedge clk);
    pend_m = 1; cnt_m = 0; set_expected_move();
    @(negedge clk);
    #1;
    chk(mv_valid == 1'b1, "R8 issue after ack", int'(mv_valid), 1);
    service_move();
    for (int la = 0; la < N; la++) read_line(la);

    psi = 1; interval = CNTW'(psi);
    for (int i = 0; i < 5; i++) read_line(i);
    psi = 0; interval = '0;
    for (int i = 0; i < 20; i++) write_line(i % N, 500 + i);
    chk(mv_valid == 1'b0, "R9 interval zero disables", int'(mv_valid), 0);
    for (int la = 0; la < N; la++) read_line(la);

    finish_run();
  end
endmodule